// File: doc/BRIEF.md
# Decode-Stage Issue Interlock

This block guards the decode stage of a five-stage in-order pipeline: fetch, decode, execute, memory access, writeback. Each cycle it sees the instruction waiting in decode: its class, its destination register, and up to three source register indices, each with its own valid bit. It raises `stall` when any valid source is still being produced by an earlier instruction. It also raises `stall` while the memory-access stage is still occupied by an earlier long operation.

Each register has a small countdown that holds the number of cycles a consumer must still wait. A single busy counter tracks the remaining extra cycles of memory-access occupancy. An instruction leaves decode in a cycle where it is valid, not stalled and not flushed. At that point it loads its destination countdown from its class, and it loads the busy counter with its extra occupancy. A flush discards the instruction in decode and undoes the marks of the instruction that left decode in the previous cycle.

Top module: `issue_interlock`

## Requirements
- R1: A synchronous reset clears every register countdown and the busy counter. Right after reset, no source read causes a stall, even if a long operation was marked before the reset.
- R2: Classes 0 (ALU), 1 (multiply), 12 (float compare) and 13 (stream get) let a dependent instruction leave decode in the very next cycle, with zero stall cycles.
- R3: A dependent instruction presented in the next cycle stalls 1 cycle behind class 3 (shift). It stalls 2 cycles behind class 15 (load) and behind class 5 (branch and link).
- R4: A dependent instruction stalls 3 cycles behind class 7 (float arithmetic) and behind class 10 (integer to float). It stalls 4 cycles behind class 9 (float to integer).
- R5: A dependent instruction stalls 31 cycles behind class 2 (integer divide). It stalls 27 cycles behind class 8 (float divide) and 26 cycles behind class 11 (float square root).
- R6: After an instruction with memory-access occupancy N leaves decode, every following instruction stalls N-1 cycles, even with no source overlap. N is 2 for classes 6, 7 and 10, 3 for class 9, 25 for class 11, 26 for class 8 and 31 for class 2. N is 1 for every other class.
- R7: Classes 4 (branch), 6 (cache control) and 14 (store or stream put) mark no register as pending.
- R8: Register 0 is never marked pending, so reading it never stalls.
- R9: Each of the three source slots is checked. A slot whose valid bit is low never causes a stall.
- R10: An instruction held in decode by a stall changes no countdown and does not load the busy counter.
- R11: With `flush` high, the instruction in decode does not leave decode. The destination mark and busy load of the instruction that left decode in the previous cycle are cleared.
- R12: A pending register does not stall a reader of a different register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Kill the decode instruction and the one just issued |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_class | input | 4 | Instruction class code |
| dec_dst | input | IW (5) | Destination register index |
| src_a | input | IW (5) | First source index |
| src_b | input | IW (5) | Second source index |
| src_c | input | IW (5) | Third source index |
| src_vld | input | 3 | Valid bits for sources a (bit 0), b (bit 1), c (bit 2) |
| stall | output | 1 | Hold the decode instruction this cycle |

## Verification
The assertions assume the upstream stage keeps `dec_class` and `dec_dst` stable while an instruction waits. They also assume `flush` only refers to the instruction that left decode one cycle earlier, and that the instruction in decode is not issued in a flush cycle. The stimulus follows these rules: every instruction is held until its stall clears, and every flush is raised either alone or together with a decode instruction that is meant to be discarded. The bench lets all counters drain between vectors, so each stall count it measures comes from a single producer–consumer pair.

// File: rtl/issue_interlock.sv
module issue_interlock #(
  parameter int NREG = 32,
  parameter int IW   = $clog2(NREG),
  parameter int CW   = 6,
  parameter int BW   = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          dec_valid,
  input  logic [3:0]    dec_class,
  input  logic [IW-1:0] dec_dst,
  input  logic [IW-1:0] src_a,
  input  logic [IW-1:0] src_b,
  input  logic [IW-1:0] src_c,
  input  logic [2:0]    src_vld,
  output logic          stall
);

  localparam logic [3:0] K_ALU = 4'd0, K_MUL = 4'd1, K_DIV = 4'd2, K_SHIFT = 4'd3,
                         K_BR = 4'd4, K_BRLINK = 4'd5, K_CACHE = 4'd6, K_FARITH = 4'd7,
                         K_FDIV = 4'd8, K_F2I = 4'd9, K_I2F = 4'd10, K_FSQRT = 4'd11,
                         K_FCMP = 4'd12, K_SGET = 4'd13, K_STORE = 4'd14, K_LOAD = 4'd15;

  // cycles a consumer must wait after the producer leaves decode (latency - 2)
  function automatic logic [CW-1:0] wait_of(input logic [3:0] c);
    case (c)
      K_SHIFT:          wait_of = CW'(1);
      K_BRLINK, K_LOAD: wait_of = CW'(2);
      K_FARITH, K_I2F:  wait_of = CW'(3);
      K_F2I:            wait_of = CW'(4);
      K_FSQRT:          wait_of = CW'(26);
      K_FDIV:           wait_of = CW'(27);
      K_DIV:            wait_of = CW'(31);
      default:          wait_of = '0;
    endcase
  endfunction

  // extra memory-access cycles beyond the first
  function automatic logic [BW-1:0] hold_of(input logic [3:0] c);
    case (c)
      K_CACHE, K_FARITH, K_I2F: hold_of = BW'(1);
      K_F2I:                    hold_of = BW'(2);
      K_FSQRT:                  hold_of = BW'(24);
      K_FDIV:                   hold_of = BW'(25);
      K_DIV:                    hold_of = BW'(30);
      default:                  hold_of = '0;
    endcase
  endfunction

  function automatic logic writes(input logic [3:0] c);
    writes = !(c == K_BR || c == K_CACHE || c == K_STORE);
  endfunction

  logic [CW-1:0] cnt [NREG];
  logic [BW-1:0] busy;
  logic [IW-1:0] last_dst;
  logic          last_mark, last_busy;
  logic          pend, issue, mark;

  always_comb begin
    pend = (busy != '0);
    if (src_vld[0] && cnt[src_a] != '0) pend = 1'b1;
    if (src_vld[1] && cnt[src_b] != '0) pend = 1'b1;
    if (src_vld[2] && cnt[src_c] != '0) pend = 1'b1;
  end

  assign stall = dec_valid & pend;
  assign issue = dec_valid & ~pend & ~flush;
  assign mark  = issue & writes(dec_class) & (dec_dst != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) cnt[i] <= '0;
      busy      <= '0;
      last_dst  <= '0;
      last_mark <= 1'b0;
      last_busy <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (mark && dec_dst == IW'(i))
          cnt[i] <= wait_of(dec_class);
        else if (flush && last_mark && last_dst == IW'(i))
          cnt[i] <= '0;
        else if (cnt[i] != '0)
          cnt[i] <= cnt[i] - CW'(1);
      end
      if (flush && last_busy)  busy <= '0;
      else if (issue)          busy <= hold_of(dec_class);
      else if (busy != '0)     busy <= busy - BW'(1);
      last_dst  <= dec_dst;
      last_mark <= mark;
      last_busy <= issue && (hold_of(dec_class) != '0);
    end
  end

  p_div_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !stall && !flush && dec_class == K_DIV) |=> busy == BW'(30));

  p_busy_count_r6: assert property (@(posedge clk) disable iff (rst)
    (busy != '0 && !flush) |=> busy == $past(busy) - BW'(1));

  p_nodst_r7: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !stall && !flush && !writes(dec_class) && cnt[dec_dst] == '0)
      |=> cnt[$past(dec_dst)] == '0);

  p_zero_ready_r8: assert property (@(posedge clk) disable iff (rst) cnt[0] == '0);

  p_stall_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && stall && cnt[dec_dst] == '0) |=> cnt[$past(dec_dst)] == '0);

  p_flush_undo_r11: assert property (@(posedge clk) disable iff (rst)
    (flush && last_mark) |=> cnt[$past(last_dst)] == '0);

endmodule

// File: tb/issue_interlock_test.sv
`timescale 1ns/1ps
module issue_interlock_test;
  logic       clk = 1'b0;
  logic       rst, flush, dec_valid;
  logic [3:0] dec_class;
  logic [4:0] dec_dst, src_a, src_b, src_c;
  logic [2:0] src_vld;
  logic       stall;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  issue_interlock uut (.clk(clk), .rst(rst), .flush(flush), .dec_valid(dec_valid),
    .dec_class(dec_class), .dec_dst(dec_dst), .src_a(src_a), .src_b(src_b),
    .src_c(src_c), .src_vld(src_vld), .stall(stall));

  // {class, producer dst, consumer src, slot, valid, expected stalls, requirement}
  localparam int NV = 23;
  localparam logic [31:0] VEC [NV] = '{
    // R2
    {1'b0, 4'd0,  5'd3,  5'd3,  2'd0, 1'b1, 6'd0,  8'd2},
    {1'b0, 4'd1,  5'd4,  5'd4,  2'd1, 1'b1, 6'd0,  8'd2},
    {1'b0, 4'd12, 5'd14, 5'd14, 2'd0, 1'b1, 6'd0,  8'd2},
    {1'b0, 4'd13, 5'd15, 5'd15, 2'd2, 1'b1, 6'd0,  8'd2},
    // R3
    {1'b0, 4'd3,  5'd5,  5'd5,  2'd0, 1'b1, 6'd1,  8'd3},
    {1'b0, 4'd15, 5'd6,  5'd6,  2'd0, 1'b1, 6'd2,  8'd3},
    {1'b0, 4'd5,  5'd7,  5'd7,  2'd1, 1'b1, 6'd2,  8'd3},
    // R4
    {1'b0, 4'd7,  5'd8,  5'd8,  2'd0, 1'b1, 6'd3,  8'd4},
    {1'b0, 4'd10, 5'd9,  5'd9,  2'd0, 1'b1, 6'd3,  8'd4},
    {1'b0, 4'd9,  5'd10, 5'd10, 2'd0, 1'b1, 6'd4,  8'd4},
    // R5
    {1'b0, 4'd2,  5'd13, 5'd13, 2'd0, 1'b1, 6'd31, 8'd5},
    {1'b0, 4'd8,  5'd11, 5'd11, 2'd0, 1'b1, 6'd27, 8'd5},
    {1'b0, 4'd11, 5'd12, 5'd12, 2'd0, 1'b1, 6'd26, 8'd5},
    // R6
    {1'b0, 4'd6,  5'd20, 5'd5,  2'd0, 1'b1, 6'd1,  8'd6},
    {1'b0, 4'd2,  5'd16, 5'd1,  2'd0, 1'b1, 6'd30, 8'd6},
    {1'b0, 4'd8,  5'd17, 5'd1,  2'd2, 1'b1, 6'd25, 8'd6},
    // R7
    {1'b0, 4'd14, 5'd20, 5'd20, 2'd0, 1'b1, 6'd0,  8'd7},
    {1'b0, 4'd4,  5'd21, 5'd21, 2'd1, 1'b1, 6'd0,  8'd7},
    // R8
    {1'b0, 4'd15, 5'd0,  5'd0,  2'd0, 1'b1, 6'd0,  8'd8},
    // R9
    {1'b0, 4'd15, 5'd22, 5'd22, 2'd2, 1'b1, 6'd2,  8'd9},
    {1'b0, 4'd15, 5'd6,  5'd6,  2'd0, 1'b0, 6'd0,  8'd9},
    {1'b0, 4'd3,  5'd23, 5'd23, 2'd1, 1'b1, 6'd1,  8'd9},
    // R12
    {1'b0, 4'd15, 5'd6,  5'd7,  2'd0, 1'b1, 6'd0,  8'd12}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // present one instruction, hold it until it leaves decode, return stall cycles
  task automatic present(input logic [3:0] c, input logic [4:0] d, input logic [4:0] a,
                         input logic [4:0] b, input logic [4:0] e, input logic [2:0] v,
                         output int n);
    @(negedge clk);
    dec_valid = 1'b1; dec_class = c; dec_dst = d;
    src_a = a; src_b = b; src_c = e; src_vld = v;
    n = 0;
    #1;
    while (stall && n < 200) begin
      n++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 dec_valid = 1'b0; src_vld = 3'b000;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1; flush = 1'b0; dec_valid = 1'b0; dec_class = '0; dec_dst = '0;
    src_a = '0; src_b = '0; src_c = '0; src_vld = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state leaves all registers ready
    present(4'd0, 5'd31, 5'd5, 5'd9, 5'd17, 3'b111, n);
    check(n == 0, "R1 reset state", n, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] w;
      logic [4:0]  s [3];
      logic [2:0]  vb;
      w = VEC[i];
      s[0] = 5'd0; s[1] = 5'd0; s[2] = 5'd0; vb = 3'b000;
      s[w[16:15]] = w[21:17];
      vb[w[16:15]] = w[14];
      present(w[30:27], w[26:22], 5'd0, 5'd0, 5'd0, 3'b000, n);
      present(4'd0, 5'd31, s[0], s[1], s[2], vb, n);
      checks++;
      if (n != int'(w[13:8])) begin
        fails++;
        $display("FAIL R%0d vector %0d: actual %0d stalls expected %0d",
                 w[7:0], i, n, w[13:8]);
      end
      idle(40);
    end

    // R1: reset discards a pending divide
    present(4'd2, 5'd5, 5'd0, 5'd0, 5'd0, 3'b000, n);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    present(4'd0, 5'd31, 5'd5, 5'd0, 5'd0, 3'b001, n);
    check(n == 0, "R1 reset clears pending", n, 0);
    idle(40);

    // R11: flush undoes the divide issued one cycle earlier
    present(4'd2, 5'd13, 5'd0, 5'd0, 5'd0, 3'b000, n);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    present(4'd0, 5'd31, 5'd13, 5'd0, 5'd0, 3'b001, n);
    check(n == 0, "R11 flush undoes prior issue", n, 0);
    idle(40);

    // R11: instruction in decode during flush is discarded
    @(negedge clk); flush = 1'b1;
    present(4'd15, 5'd9, 5'd0, 5'd0, 5'd0, 3'b000, n);
    flush = 1'b0;
    present(4'd0, 5'd31, 5'd9, 5'd0, 5'd0, 3'b001, n);
    check(n == 0, "R11 flush discards decode instruction", n, 0);
    idle(40);

    // R10: a stalled divide marks nothing and loads no busy count
    present(4'd8, 5'd1, 5'd0, 5'd0, 5'd0, 3'b000, n);
    @(negedge clk);
    dec_valid = 1'b1; dec_class = 4'd2; dec_dst = 5'd2; src_vld = 3'b000;
    begin
      int held = 0;
      for (int k = 0; k < 5; k++) begin
        #1 if (stall) held++;
        @(negedge clk);
      end
      dec_valid = 1'b0;
      check(held == 5, "R10 divide held behind busy", held, 5);
    end
    idle(40);
    present(4'd0, 5'd31, 5'd2, 5'd0, 5'd0, 3'b001, n);
    check(n == 0, "R10 stalled destination not marked", n, 0);
    present(4'd0, 5'd30, 5'd0, 5'd0, 5'd0, 3'b000, n);
    check(n == 0, "R10 stalled instruction loaded no busy", n, 0);
    idle(10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule